// File: doc/BRIEF.md
# Flash Erase-Block Parity Commit Engine

This engine protects the data pages of a single flash erase block with one XOR parity page. During a write session the host streams the block's data pages one byte per beat, in page order. The engine folds each byte into a page-sized accumulator held in internal RAM. Once the final data page has been taken in, it streams the parity page back out so the host can program it into the reserved page or pages at the end of the block. Programming that last page is what commits the block.

In a recovery session the host names the page that its ECC could not correct. It then streams every other page of the block, with the parity page carrying the index just past the last data page. The engine XORs these pages together and streams out the rebuilt page. Both sessions use valid/ready handshakes on the input and output streams. A beat that carries an unexpected page index is flagged as a sequence error.

Top module: `parity_commit_engine`

## Requirements
- R1: During and right after a synchronous active-high reset, `in_ready_o`, `out_valid_o`, `out_last_o` and `seq_err_o` are all 0 and the engine is idle.
- R2: A `blk_start_i` pulse while idle opens a write session, and `in_ready_o` is 1 from the next cycle. The session expects data pages with indices 0 to DATA_PAGES-1 (DATA_PAGES = PAGES_PER_BLOCK - PARITY_PAGES) in ascending order. Each page is PAGE_BYTES beats, and beat b of a page is byte b.
- R3: In the cycle after the final beat of a write session is accepted, `out_valid_o` rises. The engine then emits PARITY_PAGES back-to-back copies of the parity page, PARITY_PAGES*PAGE_BYTES beats in total. Byte b of each copy is the XOR of byte b of every data page. `out_last_o` marks only the final beat, and the engine goes idle after that beat is taken.
- R4: An input beat is consumed only in a cycle where `in_valid_i` and `in_ready_o` are both 1. While `out_valid_o` is 1 and `out_ready_i` is 0, `out_data_o` and `out_last_o` hold their values and `out_valid_o` stays 1.
- R5: A beat whose `in_page_i` differs from the expected page index is consumed but changes neither the accumulator nor the position in the stream, and `seq_err_o` is 1 in the following cycle only.
- R6: A `rec_start_i` pulse while idle, with `rec_page_i` no greater than DATA_PAGES, opens a recovery session. The session expects indices 0 to DATA_PAGES in ascending order with the failed index left out, where index DATA_PAGES is the parity page. It then emits one PAGE_BYTES-beat page equal to the failed page, with `out_last_o` on its final beat.
- R7: A `rec_start_i` pulse while idle with `rec_page_i` greater than DATA_PAGES is refused: `seq_err_o` is 1 in the next cycle and the engine stays idle.
- R8: Every session starts from an empty accumulator, so nothing from an earlier session affects its result.
- R9: Command inputs have no effect outside the idle state. When `blk_start_i` and `rec_start_i` arrive together while idle, the write session wins.
- R10: `in_ready_o` is 0 while idle and while emitting. `out_valid_o` is 1 only while emitting, so the two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start_i | input | 1 | Open a write session for a new block |
| rec_start_i | input | 1 | Open a recovery session |
| rec_page_i | input | PIDX_W | Index of the failed page for recovery |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Engine accepts input beats |
| in_page_i | input | PIDX_W | Page index carried by the input beat |
| in_data_i | input | 8 | Input data byte |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Consumer takes the output beat |
| out_data_o | output | 8 | Parity or rebuilt byte |
| out_last_o | output | 1 | Final beat of the emitted stream |
| seq_err_o | output | 1 | One-cycle pulse for a misordered beat or a refused recovery |

## Verification
The assertions check four things on every cycle. Input readiness and output validity are never both high. An output beat that is held stalled stays stable, and `out_last_o` only appears with `out_valid_o`. `seq_err_o` and any rise of `in_ready_o` are each traceable to the input or command of the previous cycle. A refused recovery leaves the engine idle, and the write session wins when both commands arrive together. Whether the parity and rebuilt bytes are numerically correct can only be shown by the bench scenarios. These scenarios stream whole blocks, with gaps on the input and stalls on the output, and include a misordered beat and commands issued mid-session. They also rebuild a middle page, the first page and the parity page itself, and run a second block after a recovery to show that nothing carries over between sessions.

// File: rtl/parity_commit_pkg.sv
package parity_commit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_EMIT = 2'd2
  } eng_state_t;
endpackage

// File: rtl/parity_acc_ram.sv
module parity_acc_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/page_tracker.sv
module page_tracker #(
  parameter int PAGE_BYTES = 64,
  parameter int DATA_PAGES = 7,
  parameter int PIDX_W     = 4,
  parameter int BW         = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [PIDX_W-1:0] skip_i,
  input  logic              adv_i,
  output logic [PIDX_W-1:0] exp_page_o,
  output logic [BW-1:0]     byte_o,
  output logic [BW-1:0]     byte_nxt_o,
  output logic              fresh_o,
  output logic              all_done_o
);
  localparam int LAST_BYTE = PAGE_BYTES - 1;
  localparam int DCW       = $clog2(DATA_PAGES + 1);

  logic [PIDX_W-1:0] exp_q, skip_q, after_page;
  logic [BW-1:0]     byte_q;
  logic [DCW-1:0]    done_q;
  logic              fresh_q, page_end;

  assign page_end   = adv_i && (byte_q == BW'(LAST_BYTE));
  assign byte_nxt_o = !adv_i ? byte_q : (page_end ? '0 : byte_q + 1'b1);
  assign all_done_o = page_end && (done_q == DCW'(DATA_PAGES - 1));

  always_comb begin
    after_page = exp_q + PIDX_W'(1);
    if (after_page == skip_q) after_page = exp_q + PIDX_W'(2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q   <= '0;
      skip_q  <= '0;
      byte_q  <= '0;
      done_q  <= '0;
      fresh_q <= 1'b1;
    end else if (load_i) begin
      skip_q  <= skip_i;
      exp_q   <= (skip_i == '0) ? PIDX_W'(1) : '0;
      byte_q  <= '0;
      done_q  <= '0;
      fresh_q <= 1'b1;
    end else begin
      byte_q <= byte_nxt_o;
      if (page_end) begin
        exp_q   <= after_page;
        done_q  <= done_q + 1'b1;
        fresh_q <= 1'b0;
      end
    end
  end

  assign exp_page_o = exp_q;
  assign byte_o     = byte_q;
  assign fresh_o    = fresh_q;
endmodule

// File: rtl/parity_commit_engine.sv
module parity_commit_engine
  import parity_commit_pkg::*;
#(
  parameter int PAGE_BYTES      = 64,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int PARITY_PAGES    = 1,
  localparam int PIDX_W         = $clog2(PAGES_PER_BLOCK + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_start_i,
  input  logic              rec_start_i,
  input  logic [PIDX_W-1:0] rec_page_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [PIDX_W-1:0] in_page_i,
  input  logic [7:0]        in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic              out_last_o,
  output logic              seq_err_o
);
  localparam int DATA_PAGES = PAGES_PER_BLOCK - PARITY_PAGES;
  localparam int BW         = $clog2(PAGE_BYTES);
  localparam int CW         = $clog2(PARITY_PAGES + 1);
  localparam int LAST_BYTE  = PAGE_BYTES - 1;

  eng_state_t        state_q;
  logic [CW-1:0]     copies_q, ecopy_q;
  logic [BW-1:0]     ebyte_q, rd_addr, cur_byte, nxt_byte;
  logic [PIDX_W-1:0] exp_page, skip_sel;
  logic [7:0]        rd_q, wr_data;
  logic              err_q, idle, go_wr, go_rec, bad_rec, load;
  logic              in_hs, match, adv, out_hs, elast, clast, fresh, all_done;

  assign idle    = (state_q == ST_IDLE);
  assign go_wr   = idle && blk_start_i;
  assign go_rec  = idle && !blk_start_i && rec_start_i && (rec_page_i <= PIDX_W'(DATA_PAGES));
  assign bad_rec = idle && !blk_start_i && rec_start_i && (rec_page_i > PIDX_W'(DATA_PAGES));
  assign load    = go_wr || go_rec;
  assign skip_sel = go_wr ? PIDX_W'(DATA_PAGES) : rec_page_i;

  assign in_hs  = in_valid_i && (state_q == ST_FILL);
  assign match  = (in_page_i == exp_page);
  assign adv    = in_hs && match;
  assign out_hs = (state_q == ST_EMIT) && out_ready_i;
  assign elast  = (ebyte_q == BW'(LAST_BYTE));
  assign clast  = (ecopy_q == copies_q - 1'b1);

  page_tracker #(
    .PAGE_BYTES(PAGE_BYTES), .DATA_PAGES(DATA_PAGES), .PIDX_W(PIDX_W), .BW(BW)
  ) trk_i (
    .clk(clk), .rst(rst), .load_i(load), .skip_i(skip_sel), .adv_i(adv),
    .exp_page_o(exp_page), .byte_o(cur_byte), .byte_nxt_o(nxt_byte),
    .fresh_o(fresh), .all_done_o(all_done)
  );

  always_comb begin
    case (state_q)
      ST_FILL: rd_addr = nxt_byte;
      ST_EMIT: rd_addr = out_hs ? (elast ? '0 : ebyte_q + 1'b1) : ebyte_q;
      default: rd_addr = '0;
    endcase
  end

  assign wr_data = fresh ? in_data_i : (in_data_i ^ rd_q);

  parity_acc_ram #(.DEPTH(PAGE_BYTES), .AW(BW), .DW(8)) ram_i (
    .clk(clk), .we_i(adv), .waddr_i(cur_byte), .wdata_i(wr_data),
    .raddr_i(rd_addr), .rdata_o(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      copies_q <= CW'(1);
      ebyte_q  <= '0;
      ecopy_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= (in_hs && !match) || bad_rec;
      case (state_q)
        ST_IDLE: if (load) begin
          state_q  <= ST_FILL;
          copies_q <= go_wr ? CW'(PARITY_PAGES) : CW'(1);
        end
        ST_FILL: if (all_done) begin
          state_q <= ST_EMIT;
          ebyte_q <= '0;
          ecopy_q <= '0;
        end
        ST_EMIT: if (out_hs) begin
          ebyte_q <= elast ? '0 : ebyte_q + 1'b1;
          if (elast) begin
            ecopy_q <= ecopy_q + 1'b1;
            if (clast) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o  = (state_q == ST_FILL);
  assign out_valid_o = (state_q == ST_EMIT);
  assign out_data_o  = rd_q;
  assign out_last_o  = (state_q == ST_EMIT) && elast && clast;
  assign seq_err_o   = err_q;
endmodule

// File: rtl/parity_commit_checker.sv
module parity_commit_checker #(
  parameter int DATA_PAGES = 7,
  parameter int PIDX_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              blk_start_i,
  input logic              rec_start_i,
  input logic [PIDX_W-1:0] rec_page_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [7:0]        out_data_o,
  input logic              out_last_o,
  input logic              seq_err_o
);
  logic idle;
  assign idle = !in_ready_o && !out_valid_o;

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(in_ready_o && out_valid_o));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  assert_last_valid_R3: assert property (@(posedge clk) disable iff (rst)
    out_last_o |-> out_valid_o);

  assert_err_cause_R5: assert property (@(posedge clk) disable iff (rst)
    seq_err_o |-> $past((in_valid_i && in_ready_o) || rec_start_i));

  assert_open_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready_o) |-> $past(blk_start_i || rec_start_i));

  assert_refuse_R7: assert property (@(posedge clk) disable iff (rst)
    (idle && rec_start_i && !blk_start_i && (rec_page_i > PIDX_W'(DATA_PAGES)))
      |=> (!in_ready_o && seq_err_o));

  assert_priority_R9: assert property (@(posedge clk) disable iff (rst)
    (idle && blk_start_i && rec_start_i) |=> (in_ready_o && !seq_err_o));
endmodule

bind parity_commit_engine parity_commit_checker #(
  .DATA_PAGES(DATA_PAGES), .PIDX_W(PIDX_W)
) chk_i (
  .clk(clk), .rst(rst), .blk_start_i(blk_start_i), .rec_start_i(rec_start_i),
  .rec_page_i(rec_page_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
  .out_last_o(out_last_o), .seq_err_o(seq_err_o)
);

// File: tb/parity_commit_engine_tb.sv
module parity_commit_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PB  = 64;
  localparam int PPB = 8;
  localparam int PP  = 1;
  localparam int DP  = PPB - PP;
  localparam int PW  = $clog2(PPB + 1);

  logic clk = 0, rst = 1;
  logic blk_start_i = 0, rec_start_i = 0, in_valid_i = 0, out_ready_i = 0;
  logic [PW-1:0] rec_page_i = '0, in_page_i = '0;
  logic [7:0] in_data_i = '0;
  logic in_ready_o, out_valid_o, out_last_o, seq_err_o;
  logic [7:0] out_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_commit_engine #(.PAGE_BYTES(PB), .PAGES_PER_BLOCK(PPB), .PARITY_PAGES(PP)) dut_i (
    .clk(clk), .rst(rst), .blk_start_i(blk_start_i), .rec_start_i(rec_start_i),
    .rec_page_i(rec_page_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_page_i(in_page_i), .in_data_i(in_data_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_data_o(out_data_o), .out_last_o(out_last_o),
    .seq_err_o(seq_err_o)
  );

  int checks = 0, errors = 0;

  // behavioural reference state
  int m_st = 0, m_skip = 0, m_exp = 0, m_done = 0, m_byte = 0;
  int m_ebyte = 0, m_ecopy = 0, m_copies = 1;
  bit m_fresh = 1, m_err = 0;
  logic [7:0] m_acc [PB];
  logic [7:0] cap [PB*PP];
  int cap_n = 0;
  logic [7:0] par1 [PB];

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] gen(int seed, int p, int b);
    return 8'(seed * 29 + p * 53 + b * 7 + p * b * 3 + (seed << p));
  endfunction

  task automatic model_step();
    m_err = 0;
    case (m_st)
      0: if (blk_start_i) begin
           m_st = 1; m_skip = DP; m_exp = 0; m_done = 0; m_byte = 0; m_fresh = 1; m_copies = PP;
         end else if (rec_start_i) begin
           if (int'(rec_page_i) > DP) m_err = 1;
           else begin
             m_st = 1; m_skip = int'(rec_page_i); m_exp = (m_skip == 0) ? 1 : 0;
             m_done = 0; m_byte = 0; m_fresh = 1; m_copies = 1;
           end
         end
      1: if (in_valid_i) begin
           if (int'(in_page_i) == m_exp) begin
             m_acc[m_byte] = m_fresh ? in_data_i : (m_acc[m_byte] ^ in_data_i);
             m_byte++;
             if (m_byte == PB) begin
               m_byte = 0; m_fresh = 0; m_done++; m_exp++;
               if (m_exp == m_skip) m_exp++;
               if (m_done == DP) begin m_st = 2; m_ebyte = 0; m_ecopy = 0; end
             end
           end else m_err = 1;
         end
      default: if (out_ready_i) begin
           m_ebyte++;
           if (m_ebyte == PB) begin
             m_ebyte = 0; m_ecopy++;
             if (m_ecopy == m_copies) m_st = 0;
           end
         end
    endcase
  endtask

  task automatic compare();
    check(in_ready_o == (m_st == 1), "R10 in_ready", in_ready_o, m_st == 1);
    check(out_valid_o == (m_st == 2), "R10 out_valid", out_valid_o, m_st == 2);
    check(seq_err_o == m_err, "R5 seq_err", seq_err_o, m_err);
    if (m_st == 2) begin
      check(out_data_o == m_acc[m_ebyte], "R3 out_data", out_data_o, m_acc[m_ebyte]);
      check(out_last_o == (m_ebyte == PB-1 && m_ecopy == m_copies-1), "R3 out_last",
            out_last_o, (m_ebyte == PB-1 && m_ecopy == m_copies-1));
    end else check(!out_last_o, "R10 out_last idle", out_last_o, 0);
  endtask

  task automatic tick();
    if (out_valid_o && out_ready_i && cap_n < PB*PP) begin cap[cap_n] = out_data_o; cap_n++; end
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic send_beat(int pg, logic [7:0] d);
    bit acc;
    in_valid_i = 1; in_page_i = PW'(pg); in_data_i = d;
    do begin acc = in_ready_o; tick(); end while (!acc);
    in_valid_i = 0;
  endtask

  task automatic drain(bit stall);
    int k = 0;
    cap_n = 0;
    while (out_valid_o) begin
      out_ready_i = stall ? ((k % 3) != 1) : 1'b1;
      tick(); k++;
    end
    out_ready_i = 0;
  endtask

  task automatic write_block(int seed, bit gappy, bit bad, bit busy_cmd, bit both_cmd);
    blk_start_i = 1; rec_start_i = both_cmd; rec_page_i = '0;
    tick();
    blk_start_i = 0; rec_start_i = 0;
    for (int p = 0; p < DP; p++)
      for (int b = 0; b < PB; b++) begin
        if (gappy && ((p + b) % 5 == 0)) tick();
        if (bad && p == 2 && b == 10) begin
          send_beat(5, 8'hFF);
          check(seq_err_o == 1'b1, "R5 misordered beat flagged", seq_err_o, 1);
        end
        if (busy_cmd && p == 3 && b == 0) begin
          rec_start_i = 1; rec_page_i = PW'(2); blk_start_i = 1;
          tick();
          rec_start_i = 0; blk_start_i = 0;
          check(in_ready_o == 1'b1, "R9 command while busy ignored", in_ready_o, 1);
        end
        send_beat(p, gen(seed, p, b));
      end
    check(out_valid_o == 1'b1, "R3 parity valid after last beat", out_valid_o, 1);
    drain(gappy);
    check(cap_n == PB*PP, "R3 parity beat count", cap_n, PB*PP);
    for (int b = 0; b < PB; b++) begin
      logic [7:0] x = '0;
      for (int p = 0; p < DP; p++) x ^= gen(seed, p, b);
      check(cap[b] == x, "R3 R8 parity byte vs XOR", cap[b], x);
    end
  endtask

  task automatic recover(int f, int seed);
    rec_start_i = 1; rec_page_i = PW'(f);
    tick();
    rec_start_i = 0;
    for (int p = 0; p <= DP; p++) begin
      if (p == f) continue;
      for (int b = 0; b < PB; b++) send_beat(p, (p == DP) ? par1[b] : gen(seed, p, b));
    end
    drain(1'b1);
    check(cap_n == PB, "R6 rebuilt beat count", cap_n, PB);
    for (int b = 0; b < PB; b++) begin
      logic [7:0] e = (f == DP) ? par1[b] : gen(seed, f, b);
      check(cap[b] == e, "R6 rebuilt byte", cap[b], e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < PB; i++) m_acc[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!in_ready_o && !out_valid_o && !seq_err_o && !out_last_o, "R1 reset outputs",
          {in_ready_o, out_valid_o, seq_err_o, out_last_o}, 0);
    rst = 0;
    tick();
    check(!in_ready_o && !out_valid_o, "R1 idle after reset", {in_ready_o, out_valid_o}, 0);

    write_block(1, 0, 0, 0, 0);                 // R2 R3 plain stream
    for (int b = 0; b < PB; b++) par1[b] = cap[b];
    write_block(1, 1, 1, 1, 0);                 // R4 gaps/stalls, R5, R9 busy
    recover(3, 1);                              // R6 middle page
    recover(0, 1);                              // R6 first page skipped
    recover(DP, 1);                             // R6 parity page itself
    rec_start_i = 1; rec_page_i = PW'(DP + 3);  // R7 refused index
    tick();
    rec_start_i = 0;
    check(seq_err_o == 1'b1 && !in_ready_o, "R7 refused recovery", {seq_err_o, in_ready_o}, 2);
    tick();
    write_block(2, 0, 0, 0, 1);                 // R8 fresh block, R9 priority
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule